// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Bank

This block gives software the register interface of a level-2 cache controller, but it holds no cache. It sits on a simple register bus that completes each access in one cycle. The bus carries a valid strobe, a write enable, an address and write data, and it returns read data. Only the low 12 bits of the address are decoded, so the bank appears again every 4 KB.

The bank holds these registers:

- a one-bit enable (control) register;
- an auxiliary control word;
- tag latency and data latency words;
- two address-filter bounds.

Reads also return a constant identification word and a cache-type word. The size fields of the cache-type word come from auxiliary control. Every bit that a read of the cache-type word sets stays set, because the read writes its result back into the stored value. Any maintenance operation that software polls reads as already finished.

The response path is a two-state machine:

- `RSP_IDLE`: no read data is presented. `rsp_rdata` is zero.
- `RSP_READ`: the data of the read accepted on the previous edge is presented.

The transitions are:

- either state goes to `RSP_READ` when a valid read is accepted;
- either state goes to `RSP_IDLE` on any cycle without a valid read.

Accesses to unmapped offsets raise the `bad_access` pulse so that decode coverage can be observed.

Top module: `l2stub_regbank`

## Requirements
- R1: Decode uses only address bits 11:0. Any two addresses that share those bits reach the same register.
- R2: A read at offset 0x000 returns 0x410000C8. A write to 0x000 or to 0x004 changes no register and raises `bad_access`.
- R3: Offsets 0x730 up to and including 0x7FF read as zero and discard writes, without raising `bad_access`. Offsets 0x72C and 0x800 are not part of this window.
- R4: The control register at 0x100 stores bit 0 of a write. Its bits 31:1 always read as zero.
- R5: Auxiliary control (0x104), tag control (0x108), data control (0x10C), filter start (0xC00) and filter end (0xC04) store and return all 32 bits that are written.
- R6: After reset, auxiliary control reads 0x02020000 and control, tag, data, filter start and filter end read zero. `rsp_valid` and `bad_access` are low during reset.
- R7: A read at 0x004 returns the stored cache-type word ORed with v<<18 and v<<6. Here v is a 5-bit value: bits 4:2 take auxiliary bits 19:17, bit 0 takes auxiliary bit 16, and bit 1 is zero. The stored word starts at 0x1C100100.
- R8: Each read at 0x004 writes its result back into the stored cache-type word. Bits therefore accumulate, later auxiliary-control changes never clear them, and reset leaves the stored word unchanged.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as zero and ignore writes, without raising `bad_access`.
- R10: Every other offset reads as zero and ignores writes. The cycle after a valid access to such an offset, `bad_access` is high. `bad_access` is low in every cycle that does not follow a valid access.
- R11: `rsp_valid` is high, and `rsp_rdata` carries the data, exactly in the cycle after a valid read. Otherwise `rsp_rdata` is zero. A write takes effect at the edge where `req_valid` and `req_write` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 11:0 decoded |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the read |
| rsp_valid | output | 1 | Read data valid |
| bad_access | output | 1 | Unmapped-offset pulse, one cycle after the access |

## Verification
The assertions assume these input conditions:

- `req_write` and `req_addr` are meaningful only while `req_valid` is high;
- inputs are stable around the rising edge;
- reset is asserted long enough for one edge to occur.

The bench drives every input on the falling edge. After each access it leaves one idle cycle so that each response is checked on its own. Random upper address bits exercise aliasing, while the random offsets are drawn from mapped registers, the edges of the maintenance window, the quiet offsets and arbitrary values.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    localparam logic [DATA_W-1:0] ID_WORD   = 32'h4100_00C8;
    localparam logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000;

    localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CTYPE  = 12'h004;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
    localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
    localparam logic [OFF_W-1:0] OFF_TAG    = 12'h108;
    localparam logic [OFF_W-1:0] OFF_DATA   = 12'h10C;
    localparam logic [OFF_W-1:0] OFF_FSTART = 12'hC00;
    localparam logic [OFF_W-1:0] OFF_FEND   = 12'hC04;
    localparam logic [OFF_W-1:0] OFF_Q0     = 12'hF40;
    localparam logic [OFF_W-1:0] OFF_Q1     = 12'hF60;
    localparam logic [OFF_W-1:0] OFF_Q2     = 12'hF80;
    localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
    localparam logic [OFF_W-1:0] MAINT_HI   = 12'h800;

    typedef enum logic [3:0] {
        RG_ID, RG_CTYPE, RG_CTRL, RG_AUX, RG_TAG, RG_DATA,
        RG_FSTART, RG_FEND, RG_MAINT, RG_QUIET, RG_BAD
    } region_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_READ = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
    import l2stub_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output region_e          region,
    output logic             unmapped
);

    always_comb begin
        region = RG_BAD;
        if (offset >= MAINT_LO && offset < MAINT_HI) begin
            region = RG_MAINT;
        end else begin
            unique case (offset)
                OFF_ID:                region = RG_ID;
                OFF_CTYPE:             region = RG_CTYPE;
                OFF_CTRL:              region = RG_CTRL;
                OFF_AUX:               region = RG_AUX;
                OFF_TAG:               region = RG_TAG;
                OFF_DATA:              region = RG_DATA;
                OFF_FSTART:            region = RG_FSTART;
                OFF_FEND:              region = RG_FEND;
                OFF_Q0, OFF_Q1, OFF_Q2: region = RG_QUIET;
                default:               region = RG_BAD;
            endcase
        end
    end

    // read-only words count as unmapped for writes
    assign unmapped = (region == RG_BAD) ||
                      (is_write && (region == RG_ID || region == RG_CTYPE));

endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
    import l2stub_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTYPE_INIT = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_value
);

    localparam int SZ_W      = 5;
    localparam int SZ_HI_POS = 18;
    localparam int SZ_LO_POS = 6;

    logic              ctrl_q;
    logic [DATA_W-1:0] aux_q, tag_q, data_q, fstart_q, fend_q;
    logic [DATA_W-1:0] ctype_q = CTYPE_INIT;
    logic [SZ_W-1:0]   size_code;
    logic [DATA_W-1:0] size_ext;
    logic [DATA_W-1:0] ctype_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= 1'b0;
            aux_q    <= AUX_RESET;
            tag_q    <= '0;
            data_q   <= '0;
            fstart_q <= '0;
            fend_q   <= '0;
        end else if (wr_en) begin
            unique case (region)
                RG_CTRL:   ctrl_q   <= wdata[0];
                RG_AUX:    aux_q    <= wdata;
                RG_TAG:    tag_q    <= wdata;
                RG_DATA:   data_q   <= wdata;
                RG_FSTART: fstart_q <= wdata;
                RG_FEND:   fend_q   <= wdata;
                default:   ;
            endcase
        end
    end

    assign size_code = {aux_q[19:17], 1'b0, aux_q[16]};
    assign size_ext  = {{(DATA_W-SZ_W){1'b0}}, size_code};
    assign ctype_rd  = ctype_q | (size_ext << SZ_HI_POS) | (size_ext << SZ_LO_POS);

    // sticky word: no reset, only reads update it
    always_ff @(posedge clk) begin
        if (rd_en && region == RG_CTYPE) ctype_q <= ctype_rd;
    end

    always_comb begin
        unique case (region)
            RG_ID:     rd_value = ID_WORD;
            RG_CTYPE:  rd_value = ctype_rd;
            RG_CTRL:   rd_value = {{(DATA_W-1){1'b0}}, ctrl_q};
            RG_AUX:    rd_value = aux_q;
            RG_TAG:    rd_value = tag_q;
            RG_DATA:   rd_value = data_q;
            RG_FSTART: rd_value = fstart_q;
            RG_FEND:   rd_value = fend_q;
            default:   rd_value = '0;
        endcase
    end

    AST_CTYPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctype_q & $past(ctype_q)) == $past(ctype_q)); // R8
    AST_CTYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && region == RG_CTYPE) |=> $stable(ctype_q)); // R8

endmodule

// File: rtl/l2stub_rsp.sv
module l2stub_rsp
    import l2stub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              bad_req,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic              bad_access
);

    rsp_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              bad_q;

    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = rd_req ? RSP_READ : RSP_IDLE;
            RSP_READ: state_d = rd_req ? RSP_READ : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            data_q <= rd_req ? rd_value : '0;
            bad_q  <= bad_req;
        end
    end

    assign rsp_valid  = (state_q == RSP_READ);
    assign rsp_rdata  = data_q;
    assign bad_access = bad_q;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid); // R11
    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid); // R11
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_rdata == '0); // R11

endmodule

// File: rtl/l2stub_regbank.sv
module l2stub_regbank
    import l2stub_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [DATA_W-1:0] CTYPE_INIT = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_valid,
    output logic              bad_access
);

    logic [OFF_W-1:0]  offset;
    region_e           region;
    logic              unmapped;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] rd_value;

    assign offset = req_addr[OFF_W-1:0];
    assign wr_en  = req_valid && req_write;
    assign rd_en  = req_valid && !req_write;

    l2stub_decode u_decode (
        .offset   (offset),
        .is_write (req_write),
        .region   (region),
        .unmapped (unmapped)
    );

    l2stub_regs #(.CTYPE_INIT(CTYPE_INIT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .region   (region),
        .wdata    (req_wdata),
        .rd_value (rd_value)
    );

    l2stub_rsp u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_en),
        .bad_req    (req_valid && unmapped),
        .rd_value   (rd_value),
        .rsp_rdata  (rsp_rdata),
        .rsp_valid  (rsp_valid),
        .bad_access (bad_access)
    );

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset == OFF_CTRL) |=> rsp_rdata[31:1] == '0); // R4
    AST_MAINT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset >= MAINT_LO && offset < MAINT_HI)
            |=> (rsp_rdata == '0 && !bad_access)); // R3
    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset == OFF_ID) |=> rsp_rdata == ID_WORD); // R2
    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && region == RG_BAD) |=> bad_access); // R10
    AST_BAD_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !bad_access); // R10

endmodule

// File: tb/test_l2stub_regbank.sv
module test_l2stub_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_valid;
    logic        bad_access;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model
    logic        m_ctrl;
    logic [31:0] m_aux, m_tag, m_data, m_fs, m_fe;
    logic [31:0] m_ctype = 32'h1C10_0100;

    always #4 clk = ~clk;

    l2stub_regbank i_l2stub_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_valid(rsp_valid), .bad_access(bad_access)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_ctrl = 1'b0; m_aux = 32'h0202_0000; m_tag = '0; m_data = '0;
        m_fs = '0; m_fe = '0;
    endfunction

    function automatic bit is_maint(logic [11:0] o);
        return o >= 12'h730 && o < 12'h800;
    endfunction

    function automatic bit is_bad(logic [11:0] o, bit wr);
        if (is_maint(o)) return 1'b0;
        case (o)
            12'h000, 12'h004: return wr;
            12'h100, 12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04,
            12'hF40, 12'hF60, 12'hF80: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] o);
        logic [4:0]  v;
        logic [31:0] r;
        if (is_maint(o)) return '0;
        case (o)
            12'h000: return 32'h4100_00C8;
            12'h004: begin
                v = {m_aux[19:17], 1'b0, m_aux[16]};
                r = m_ctype | ({27'd0, v} << 18) | ({27'd0, v} << 6);
                m_ctype = r;
                return r;
            end
            12'h100: return {31'd0, m_ctrl};
            12'h104: return m_aux;
            12'h108: return m_tag;
            12'h10C: return m_data;
            12'hC00: return m_fs;
            12'hC04: return m_fe;
            default: return '0;
        endcase
    endfunction

    function automatic void model_write(logic [11:0] o, logic [31:0] d);
        if (is_maint(o)) return;
        case (o)
            12'h100: m_ctrl = d[0];
            12'h104: m_aux = d;
            12'h108: m_tag = d;
            12'h10C: m_data = d;
            12'hC00: m_fs = d;
            12'hC04: m_fe = d;
            default: ;
        endcase
    endfunction

    task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd, string req);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (wr) begin
            model_write(addr[11:0], wd);
            check({req, " R11 no rsp on write"}, {31'd0, rsp_valid}, 32'd0);
        end else begin
            exp = model_read(addr[11:0]);
            check({req, " R11 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
            check({req, " rdata"}, rsp_rdata, exp);
        end
        check({req, " R10 bad_access"}, {31'd0, bad_access}, {31'd0, is_bad(addr[11:0], wr)});
    endtask

    task automatic rd(logic [31:0] a, string req);
        access(1'b0, a, 32'd0, req);
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d, string req);
        access(1'b1, a, d, req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [11:0] pool [16];
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        check("R6 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R6 bad_access in reset", {31'd0, bad_access}, 32'd0);
        rst_n = 1'b1;

        // R6 reset values
        rd(32'h104, "R6 aux"); rd(32'h100, "R6 ctrl"); rd(32'h108, "R6 tag");
        rd(32'h10C, "R6 data"); rd(32'hC00, "R6 fstart"); rd(32'hC04, "R6 fend");
        // R2 identification
        rd(32'h000, "R2 id");
        wr(32'h000, 32'hFFFF_FFFF, "R2 id write");
        rd(32'h000, "R2 id after write");
        // R7 cache type from aux
        rd(32'h004, "R7 ctype default");
        wr(32'h104, 32'h000F_0000, "R5 aux");
        rd(32'h004, "R7 ctype all size bits");
        // R8 sticky
        wr(32'h104, 32'h0000_0000, "R5 aux clear");
        rd(32'h004, "R8 ctype sticky");
        wr(32'h004, 32'h0, "R2 ctype write");
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; model_reset();
        rd(32'h004, "R8 ctype survives reset");
        // R4 control mask
        wr(32'h100, 32'hFFFF_FFFF, "R4 ctrl");
        rd(32'h100, "R4 ctrl one bit");
        wr(32'h100, 32'hFFFF_FFFE, "R4 ctrl clear");
        rd(32'h100, "R4 ctrl zero");
        // R5 full registers
        wr(32'h108, 32'hA5A5_5A5A, "R5 tag"); rd(32'h108, "R5 tag");
        wr(32'hC04, 32'h1234_5678, "R5 fend"); rd(32'hC04, "R5 fend");
        // R3 window edges
        wr(32'h730, 32'hFFFF_FFFF, "R3 maint lo"); rd(32'h730, "R3 maint lo");
        rd(32'h7FC, "R3 maint hi"); rd(32'h72C, "R3 below window");
        rd(32'h800, "R3 above window");
        // R9 quiet offsets
        wr(32'hF40, 32'h1, "R9 q0"); rd(32'hF60, "R9 q1"); rd(32'hF80, "R9 q2");
        // R10 unmapped
        wr(32'h200, 32'h5, "R10 unmapped write"); rd(32'h200, "R10 unmapped read");
        // R1 aliasing
        wr(32'hABCD_E10C, 32'hCAFE_F00D, "R1 alias write");
        rd(32'h0000_010C, "R1 alias read");
        rd(32'h7777_7000, "R1 alias id");

        pool = '{12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C, 12'hC00,
                 12'hC04, 12'hF40, 12'hF60, 12'hF80, 12'h730, 12'h7FF, 12'h72C,
                 12'h800, 12'h104};
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [11:0] o;
            o = ($urandom % 4 == 0) ? 12'($urandom) : pool[$urandom % 16];
            a = {20'($urandom), o};
            access(1'($urandom), a, $urandom, "R1 R5 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule